// File: doc/BRIEF.md
# Attribute-Driven Control Register Bank

This block is a flat bank of configuration and status registers reached over a simple word-addressed read/write port. Every byte lane of every word is one field. Each field carries an access attribute fixed at elaboration. The attribute decides four things: how software reads and writes act on the field, how hardware event inputs set, clear or load it, whether another field freezes it, and which reset returns it to its default.

There are two synchronous, active-high reset inputs. `rst_cold` is the power-good reset and returns every field to its default. `rst_warm` spares sticky fields and resets all others. While either reset is high, bus accesses are ignored.

Hardware reads every field value on `field_q`. A write to a write-only field raises a one-cycle pulse on `wo_pulse`.

Top module: `regbank_attr`

## Requirements
- R1: A read-only field (plain or sticky) ignores every bus write. It changes only on reset, or in the cycle after its `hw_we` bit is 1, when it takes that field's byte of `hw_wdata`.
- R2: Sticky fields (sticky read-only, sticky read/write, sticky write-one-to-clear) hold their value through `rst_warm` and return to default only on `rst_cold`. Every other field returns to its default on either reset.
- R3: On a write-one-to-clear field, a written 1 clears that bit and a written 0 leaves it unchanged. A 1 on the field's `hw_set` bits sets those bits.
- R4: When a hardware set and a software clear hit the same bit in the same cycle, the bit ends up 1.
- R5: A read-to-set field returns its current value on a read and then becomes all ones. A written 1 clears a bit, and a written 0 changes nothing.
- R6: A lockable field ignores bus writes while bit 0 of its designated guard field is 1. The guard is sampled before the write takes effect, and a lockable field may itself guard another lockable field.
- R7: A key field is ordinary read/write storage. While its bit 0 is 1, every field that names it as guard is write-protected.
- R8: A self-clearing field takes bus writes. A 1 on its `hw_clr` bits clears those bits, and a bus write in the same cycle wins over the clear. The lockable variant also obeys its guard.
- R9: A write-once field accepts only the first write in which its byte strobe is 1. A write that leaves its strobe at 0 does not use up the one write. Either reset makes it writable again.
- R10: A write-only field always reads as 0. A write to it drives `wo_pulse` high for exactly one cycle, with the written byte on `field_q` during that pulse.
- R11: `bus_rdata` is registered and shows the addressed word one cycle after `bus_rd`. It holds its value in cycles without `bus_rd`, even if fields change.
- R12: A write changes only the byte lanes whose `bus_be` bit is 1. Lane n covers bits 8n+7 to 8n of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_cold | input | 1 | Power-good reset, synchronous, active high |
| rst_warm | input | 1 | Warm reset, synchronous, active high; spares sticky fields |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_be | input | DATA_W/8 | Byte strobes, one per lane |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| hw_we | input | NF | Per-field load enable for read-only fields |
| hw_wdata | input | NF*8 | Load values, field i at bits 8i+7:8i |
| hw_set | input | NF*8 | Per-bit set events for write-one-to-clear fields |
| hw_clr | input | NF*8 | Per-bit clear events for self-clearing fields |
| field_q | output | NF*8 | Current value of every field, field i at bits 8i+7:8i |
| wo_pulse | output | NF | One-cycle pulse on a write to a write-only field |

## Verification
The in-line properties check several rules on every cycle:
- read-only fields stay stable without a load;
- hardware set events never lose a bit;
- written ones clear;
- read-to-set fields fill after a read;
- locked fields, spent write-once fields and unstrobed read/write fields hold still;
- sticky fields survive warm reset while non-sticky ones return to default;
- read data holds between reads.

Only the bench scenarios can show the rest. These are the exact values returned through the bus, the one-cycle read latency, the lock chain where the first lock freezes a second lock bit that guards a third field, and the fact that a write-once field is not used up by an unstrobed write. The bench also confirms that write beats a same-cycle hardware clear on self-clearing fields, and that write-only data appears on the hardware side but never on reads.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  localparam int FIELD_W = 8;

  typedef enum logic [3:0] {
    FA_RO,      // read only, hardware loaded
    FA_RO_ST,   // read only, sticky
    FA_RW,      // plain read/write
    FA_RW_ST,   // read/write, sticky
    FA_W1C,     // hardware set, write one to clear
    FA_W1C_ST,  // as above, sticky
    FA_RDSET,   // set by read, write one to clear
    FA_RW_LK,   // read/write, frozen by guard
    FA_RW_KEY,  // read/write, acts as guard for others
    FA_SC,      // read/write, hardware clears
    FA_SC_LK,   // self clearing, frozen by guard
    FA_WONCE,   // first strobed write only
    FA_WONLY    // write only, reads zero, pulses
  } fattr_e;

  function automatic logic attr_sticky(fattr_e a);
    return (a == FA_RO_ST) || (a == FA_RW_ST) || (a == FA_W1C_ST);
  endfunction

  function automatic logic attr_lockable(fattr_e a);
    return (a == FA_RW_LK) || (a == FA_SC_LK);
  endfunction

endpackage

// File: rtl/regbank_wdec.sv
module regbank_wdec #(
  parameter int NUM_WORDS = 4,
  parameter int DATA_W    = 32,
  parameter int FW        = 8,
  localparam int LANES    = DATA_W / FW,
  localparam int NF       = NUM_WORDS * LANES,
  localparam int ADDR_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              rst_any,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  be,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [NF-1:0]     wr_hit,
  output logic [NF-1:0]     rd_hit,
  output logic [NF*FW-1:0]  wbytes
);

  logic wr_ok;
  logic rd_ok;
  assign wr_ok = wr_en && !rst_any;
  assign rd_ok = rd_en && !rst_any;

  for (genvar gi = 0; gi < NF; gi++) begin : g_dec
    localparam int WORD = gi / LANES;
    localparam int LANE = gi % LANES;
    logic sel;
    assign sel = (addr == ADDR_W'(WORD));
    assign wr_hit[gi] = wr_ok && sel && be[LANE];
    assign rd_hit[gi] = rd_ok && sel;
    assign wbytes[gi*FW +: FW] = wdata[LANE*FW +: FW];
  end

endmodule

// File: rtl/regbank_field.sv
module regbank_field
  import regbank_pkg::*;
#(
  parameter fattr_e          ATTR    = FA_RW,
  parameter int              FW      = FIELD_W,
  parameter logic [FW-1:0]   RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_cold,
  input  logic          rst_warm,
  input  logic          wr_hit,
  input  logic          rd_hit,
  input  logic [FW-1:0] wbyte,
  input  logic          hw_we,
  input  logic [FW-1:0] hw_wdata,
  input  logic [FW-1:0] hw_set,
  input  logic [FW-1:0] hw_clr,
  input  logic          guard_on,
  output logic [FW-1:0] q,
  output logic [FW-1:0] rd_val,
  output logic          wo_pulse
);

  localparam logic STICKY   = attr_sticky(ATTR);
  localparam logic LOCKABLE = attr_lockable(ATTR);

  logic [FW-1:0] q_r;
  logic          once_r;
  logic          wo_r;
  logic          wr_ok;

  assign wr_ok = wr_hit && !(LOCKABLE && guard_on);

  always_ff @(posedge clk) begin
    if (rst_cold || (rst_warm && !STICKY)) begin
      q_r <= RST_VAL;
    end else begin
      case (ATTR)
        FA_RO, FA_RO_ST: if (hw_we) q_r <= hw_wdata;
        FA_RW, FA_RW_ST, FA_RW_LK, FA_RW_KEY, FA_WONLY: if (wr_ok) q_r <= wbyte;
        FA_W1C, FA_W1C_ST: q_r <= (q_r & ~(wr_hit ? wbyte : '0)) | hw_set;
        FA_RDSET: begin
          if (rd_hit)      q_r <= '1;
          else if (wr_hit) q_r <= q_r & ~wbyte;
        end
        FA_SC, FA_SC_LK: begin
          if (wr_ok) q_r <= wbyte;
          else       q_r <= q_r & ~hw_clr;
        end
        FA_WONCE: if (wr_hit && !once_r) q_r <= wbyte;
        default: q_r <= q_r;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst_cold || rst_warm) begin
      once_r <= 1'b0;
      wo_r   <= 1'b0;
    end else begin
      if (ATTR == FA_WONCE && wr_hit) once_r <= 1'b1;
      wo_r <= (ATTR == FA_WONLY) && wr_hit;
    end
  end

  assign q        = q_r;
  assign rd_val   = (ATTR == FA_WONLY) ? '0 : q_r;
  assign wo_pulse = wo_r;

  logic unused_inputs;
  assign unused_inputs = ^{hw_we, hw_wdata, hw_set, hw_clr, rd_hit, guard_on};

  // ---------------- assertions ----------------
  if (ATTR == FA_RO || ATTR == FA_RO_ST) begin : g_a_ro
    p_ro_hold_r1: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
      !hw_we |=> $stable(q_r));
  end

  if (STICKY) begin : g_a_st
    p_sticky_keep_r2: assert property (@(posedge clk) disable iff (rst_cold)
      (rst_warm && !hw_we && !(|hw_set)) |=> $stable(q_r));
  end else begin : g_a_nst
    p_warm_default_r2: assert property (@(posedge clk) disable iff (rst_cold)
      rst_warm |=> (q_r == RST_VAL));
  end

  if (ATTR == FA_W1C || ATTR == FA_W1C_ST) begin : g_a_w1c
    p_w1c_clear_r3: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
      (wr_hit && !(|hw_set)) |=> ((q_r & $past(wbyte)) == '0));
    p_hwset_wins_r4: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
      (|hw_set) |=> ((q_r & $past(hw_set)) == $past(hw_set)));
  end

  if (ATTR == FA_RDSET) begin : g_a_rs
    p_read_sets_r5: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
      rd_hit |=> (q_r == '1));
  end

  if (LOCKABLE) begin : g_a_lk
    p_locked_hold_r6: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
      (guard_on && !(|hw_clr)) |=> $stable(q_r));
  end

  if (ATTR == FA_SC || ATTR == FA_SC_LK) begin : g_a_sc
    p_self_clear_r8: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
      (!wr_hit && (|hw_clr)) |=> ((q_r & $past(hw_clr)) == '0));
  end

  if (ATTR == FA_WONCE) begin : g_a_wo1
    p_once_frozen_r9: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
      once_r |=> $stable(q_r));
  end

  if (ATTR == FA_WONLY) begin : g_a_wonly
    p_wo_pulse_r10: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
      wr_hit |=> (wo_pulse && q_r == $past(wbyte)));
    p_wo_single_r10: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
      !wr_hit |=> !wo_pulse);
  end

  if (ATTR == FA_RW || ATTR == FA_RW_ST || ATTR == FA_RW_KEY) begin : g_a_rw
    p_unstrobed_hold_r12: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
      !wr_hit |=> $stable(q_r));
  end

endmodule

// File: rtl/regbank_rdata.sv
module regbank_rdata #(
  parameter int NUM_WORDS = 4,
  parameter int DATA_W    = 32,
  localparam int ADDR_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_any,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [NUM_WORDS*DATA_W-1:0] rd_vals,
  output logic [DATA_W-1:0]           rdata
);

  logic [DATA_W-1:0] words [NUM_WORDS];
  logic [DATA_W-1:0] sel_word;

  for (genvar gw = 0; gw < NUM_WORDS; gw++) begin : g_w
    assign words[gw] = rd_vals[gw*DATA_W +: DATA_W];
  end

  always_comb begin
    sel_word = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (addr == ADDR_W'(w)) sel_word = words[w];
    end
  end

  always_ff @(posedge clk) begin
    if (rst_any)    rdata <= '0;
    else if (rd_en) rdata <= sel_word;
  end

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst_any)
    !rd_en |=> $stable(rdata));

endmodule

// File: rtl/regbank_attr.sv
module regbank_attr
  import regbank_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int DATA_W    = 32,
  localparam int LANES    = DATA_W / FIELD_W,
  localparam int NF       = NUM_WORDS * LANES,
  localparam int ADDR_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  parameter fattr_e FIELD_ATTR [NF] = '{
    FA_RO,     FA_RO_ST,  FA_RW,    FA_RW_ST,
    FA_W1C,    FA_W1C_ST, FA_RDSET, FA_WONCE,
    FA_RW_KEY, FA_RW_LK,  FA_SC_LK, FA_RW_LK,
    FA_SC,     FA_WONLY,  FA_RO,    FA_RW},
  parameter int GUARD_SEL [NF] = '{
    -1, -1, -1, -1,
    -1, -1, -1, -1,
    -1,  8,  8,  9,
    -1, -1, -1, -1},
  parameter logic [NUM_WORDS*DATA_W-1:0] RESET_VAL =
    128'h5A000000_00000000_00000000_3CA50000
) (
  input  logic                  clk,
  input  logic                  rst_cold,
  input  logic                  rst_warm,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic [LANES-1:0]      bus_be,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [NF-1:0]         hw_we,
  input  logic [NF*FIELD_W-1:0] hw_wdata,
  input  logic [NF*FIELD_W-1:0] hw_set,
  input  logic [NF*FIELD_W-1:0] hw_clr,
  output logic [NF*FIELD_W-1:0] field_q,
  output logic [NF-1:0]         wo_pulse
);

  logic                  rst_any;
  logic [NF-1:0]         wr_hit;
  logic [NF-1:0]         rd_hit;
  logic [NF*FIELD_W-1:0] wbytes;
  logic [NF*FIELD_W-1:0] rd_vals;
  logic [FIELD_W-1:0]    fq [NF];

  assign rst_any = rst_cold || rst_warm;

  regbank_wdec #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W), .FW(FIELD_W)) u_wdec (
    .rst_any (rst_any),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .be      (bus_be),
    .wr_en   (bus_wr),
    .rd_en   (bus_rd),
    .wr_hit  (wr_hit),
    .rd_hit  (rd_hit),
    .wbytes  (wbytes)
  );

  for (genvar gi = 0; gi < NF; gi++) begin : g_fld
    logic guard;
    if (GUARD_SEL[gi] >= 0 && GUARD_SEL[gi] < NF) begin : g_guard
      assign guard = fq[GUARD_SEL[gi]][0];
    end else begin : g_free
      assign guard = 1'b0;
    end

    regbank_field #(
      .ATTR    (FIELD_ATTR[gi]),
      .FW      (FIELD_W),
      .RST_VAL (RESET_VAL[gi*FIELD_W +: FIELD_W])
    ) u_field (
      .clk      (clk),
      .rst_cold (rst_cold),
      .rst_warm (rst_warm),
      .wr_hit   (wr_hit[gi]),
      .rd_hit   (rd_hit[gi]),
      .wbyte    (wbytes[gi*FIELD_W +: FIELD_W]),
      .hw_we    (hw_we[gi]),
      .hw_wdata (hw_wdata[gi*FIELD_W +: FIELD_W]),
      .hw_set   (hw_set[gi*FIELD_W +: FIELD_W]),
      .hw_clr   (hw_clr[gi*FIELD_W +: FIELD_W]),
      .guard_on (guard),
      .q        (fq[gi]),
      .rd_val   (rd_vals[gi*FIELD_W +: FIELD_W]),
      .wo_pulse (wo_pulse[gi])
    );

    assign field_q[gi*FIELD_W +: FIELD_W] = fq[gi];
  end

  regbank_rdata #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W)) u_rdata (
    .clk     (clk),
    .rst_any (rst_any),
    .rd_en   (bus_rd),
    .addr    (bus_addr),
    .rd_vals (rd_vals),
    .rdata   (bus_rdata)
  );

  p_cold_clears_rdata_r2: assert property (@(posedge clk)
    rst_cold |=> (bus_rdata == '0 && wo_pulse == '0));

endmodule

// File: tb/tb_regbank_attr.sv
`timescale 1ns/1ps
module tb_regbank_attr;
  import regbank_pkg::*;

  localparam int NF = 16;

  logic          clk = 1'b0;
  logic          rst_cold = 1'b1;
  logic          rst_warm = 1'b1;
  logic [1:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [3:0]    bus_be = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_rdata;
  logic [NF-1:0] hw_we = '0;
  logic [NF*8-1:0] hw_wdata = '0;
  logic [NF*8-1:0] hw_set = '0;
  logic [NF*8-1:0] hw_clr = '0;
  logic [NF*8-1:0] field_q;
  logic [NF-1:0] wo_pulse;

  always #4 clk = ~clk;

  regbank_attr dut (
    .clk(clk), .rst_cold(rst_cold), .rst_warm(rst_warm),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .hw_we(hw_we), .hw_wdata(hw_wdata), .hw_set(hw_set), .hw_clr(hw_clr),
    .field_q(field_q), .wo_pulse(wo_pulse)
  );

  typedef struct {
    logic [31:0] exp;
    logic [31:0] mask;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  logic pend = 1'b0;
  bit   finished = 0;

  // monitor: read data is due one clock after the read strobe
  always @(posedge clk) pend <= bus_rd;

  always @(negedge clk) begin
    exp_t e;
    if (pend) begin
      if (sb_q.size() == 0) begin
        n_bad++;
        $display("FAIL R11: read data with no expected item, got %h", bus_rdata);
      end else begin
        e = sb_q.pop_front();
        n_cmp++;
        if ((bus_rdata & e.mask) !== (e.exp & e.mask)) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", e.tag,
                   bus_rdata & e.mask, e.exp & e.mask);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp,
                    input logic [31:0] mask, input string tag);
    exp_t e;
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    e.exp = exp; e.mask = mask; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic do_reset(input logic cold, input logic warm);
    @(negedge clk);
    rst_cold = cold; rst_warm = warm;
    repeat (2) @(negedge clk);
    rst_cold = 1'b0; rst_warm = 1'b0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset(1'b1, 1'b1);

    // R2: defaults after cold reset
    rd(2'd0, 32'h3CA50000, 32'hFFFFFFFF, "R2 default word0");
    rd(2'd1, 32'h00000000, 32'hFFFFFFFF, "R2 default word1");
    rd(2'd2, 32'h00000000, 32'hFFFFFFFF, "R2 default word2");
    rd(2'd3, 32'h5A000000, 32'hFFFFFFFF, "R2 default word3");

    // R1 and R12: read-only lanes ignore writes, strobes pick lanes
    wr(2'd0, 32'hFFFFFFFF, 4'b1111);
    rd(2'd0, 32'hFFFF0000, 32'hFFFFFFFF, "R1 read-only ignores write");
    wr(2'd0, 32'h11223344, 4'b0100);
    rd(2'd0, 32'hFF220000, 32'hFFFFFFFF, "R12 single lane strobe");
    @(negedge clk);
    hw_we[0] = 1'b1; hw_wdata[0 +: 8] = 8'h12;
    hw_we[1] = 1'b1; hw_wdata[8 +: 8] = 8'h34;
    @(negedge clk);
    hw_we = '0;
    rd(2'd0, 32'hFF223412, 32'hFFFFFFFF, "R1 hardware load");

    // R2: warm reset spares sticky fields
    do_reset(1'b0, 1'b1);
    rd(2'd0, 32'hFFA53400, 32'hFFFFFFFF, "R2 warm reset word0");

    // R3: write one to clear
    @(negedge clk);
    hw_set[4*8 +: 8] = 8'h0F; hw_set[5*8 +: 8] = 8'hF0;
    @(negedge clk);
    hw_set = '0;
    rd(2'd1, 32'h0000F00F, 32'hFFFFFFFF, "R3 hardware set");
    wr(2'd1, 32'h00000305, 4'b0011);
    rd(2'd1, 32'h0000F00A, 32'h0000FFFF, "R3 ones clear zeros keep");

    // R4: set and clear collide, set wins
    @(negedge clk);
    bus_addr = 2'd1; bus_wdata = 32'h00000002; bus_be = 4'b0001; bus_wr = 1'b1;
    hw_set[4*8 +: 8] = 8'h02;
    @(negedge clk);
    bus_wr = 1'b0; hw_set = '0;
    rd(2'd1, 32'h0000000A, 32'h000000FF, "R4 hardware set wins");
    wr(2'd1, 32'h00000002, 4'b0001);
    rd(2'd1, 32'h00000008, 32'h000000FF, "R3 clear without set");

    // R5: read-to-set
    wr(2'd1, 32'h000F0000, 4'b0100);
    rd(2'd1, 32'h00F00000, 32'h00FF0000, "R5 read returns prior value");
    rd(2'd1, 32'h00FF0000, 32'h00FF0000, "R5 read sets all ones");
    wr(2'd1, 32'h00000000, 4'b0100);
    rd(2'd1, 32'h00FF0000, 32'h00FF0000, "R5 zero write no effect");

    // R2: sticky write-one-to-clear survives warm reset
    do_reset(1'b0, 1'b1);
    rd(2'd1, 32'h0000F000, 32'h0000FFFF, "R2 warm reset word1");

    // R9: write once
    wr(2'd1, 32'h99000000, 4'b0111);
    rd(2'd1, 32'h00000000, 32'hFF000000, "R9 unstrobed write ignored");
    wr(2'd1, 32'h11000000, 4'b1000);
    rd(2'd1, 32'h11000000, 32'hFF000000, "R9 first write taken");
    wr(2'd1, 32'h22000000, 4'b1000);
    rd(2'd1, 32'h11000000, 32'hFF000000, "R9 second write refused");
    do_reset(1'b0, 1'b1);
    wr(2'd1, 32'h33000000, 4'b1000);
    rd(2'd1, 32'h33000000, 32'hFF000000, "R9 reset re-enables");

    // R6 and R7: key and lock chain
    wr(2'd2, 32'h44556600, 4'b1111);
    rd(2'd2, 32'h44556600, 32'hFFFFFFFF, "R6 unlocked writes");
    wr(2'd2, 32'h0B0C0D01, 4'b1111);
    rd(2'd2, 32'h0B0C0D01, 32'hFFFFFFFF, "R7 key set with same-cycle writes");
    wr(2'd2, 32'hAABBCC01, 4'b1111);
    rd(2'd2, 32'h0B0C0D01, 32'hFFFFFFFF, "R7 key blocks guarded fields");
    wr(2'd2, 32'h00000000, 4'b0001);
    wr(2'd2, 32'hAABBCC00, 4'b1111);
    rd(2'd2, 32'h0BBBCC00, 32'hFFFFFFFF, "R6 chained lock holds");

    // R8: self clearing
    wr(2'd3, 32'h000000F0, 4'b0001);
    rd(2'd3, 32'h000000F0, 32'h000000FF, "R8 write taken");
    @(negedge clk);
    hw_clr[12*8 +: 8] = 8'h30;
    @(negedge clk);
    hw_clr = '0;
    rd(2'd3, 32'h000000C0, 32'h000000FF, "R8 hardware clear");
    @(negedge clk);
    bus_addr = 2'd3; bus_wdata = 32'h0000000F; bus_be = 4'b0001; bus_wr = 1'b1;
    hw_clr[12*8 +: 8] = 8'h0F;
    @(negedge clk);
    bus_wr = 1'b0; hw_clr = '0;
    rd(2'd3, 32'h0000000F, 32'h000000FF, "R8 write beats clear");

    // R10: write only
    wr(2'd3, 32'h0000AB00, 4'b0010);
    chk({31'd0, wo_pulse[13]}, 32'd1, "R10 pulse raised");
    chk({24'd0, field_q[13*8 +: 8]}, 32'h000000AB, "R10 written byte on field_q");
    @(negedge clk);
    chk({31'd0, wo_pulse[13]}, 32'd0, "R10 pulse lasts one cycle");
    rd(2'd3, 32'h00000000, 32'h0000FF00, "R10 reads zero");
    rd(2'd3, 32'h0000000F, 32'h000000FF, "R12 other lane untouched");

    // R2: cold reset clears sticky fields too
    do_reset(1'b1, 1'b0);
    rd(2'd0, 32'h3CA50000, 32'hFFFFFFFF, "R2 cold reset word0");
    rd(2'd1, 32'h00000000, 32'h0000FF00, "R2 cold reset sticky w1c");

    // R11: read data holds between reads
    rd(2'd0, 32'h3CA50000, 32'hFFFFFFFF, "R11 read before hold");
    wr(2'd0, 32'h00770000, 4'b0100);
    chk(bus_rdata, 32'h3CA50000, "R11 holds after write");
    repeat (2) @(negedge clk);
    chk(bus_rdata, 32'h3CA50000, "R11 holds while idle");
    rd(2'd0, 32'h3C770000, 32'hFFFFFFFF, "R11 next read updates");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL R11: actual %0d pending expected 0", sb_q.size());
    end
    finished = 1;
    summary();
    $finish;
  end

endmodule